// File: doc/BRIEF.md
# Coprocessor-0 Status/Cause Exception Controller

This block keeps the system-control register set of a small MIPS-style processor. The processor mode, the interrupt enables and the software-interrupt masks are held in Status (register 12). The latest exception code, the pending software-interrupt bits and the branch-delay indication are held in Cause (register 13). The return address of the latest exception is held in EPC (register 14). The remaining register numbers are plain storage words. The pipeline reads and writes these registers through a single write port and a combinational read port. Reads are sign-extended to the width of the destination register.

When the pipeline signals an exception, the controller does three things in one cycle. It pushes the two-bit enable/mode pairs held in Status bits [5:0] one level deeper, with a cleared pair on top. It records the exception code and the branch-delay flag in Cause. It stores the restart address in EPC. A return-from-exception strobe pops the stack by one level. The controller also raises a software-interrupt request while a pending software-interrupt bit is unmasked and the global enable is set. It presents a fixed handler vector at all times.

In each cycle a priority decoder picks one operation from four named states. OP_TRAP is taken whenever the exception strobe is high. OP_RFE is taken when the return strobe is high and no exception is present. OP_WRITE is taken when only the write enable is high. OP_IDLE is taken otherwise. The decoder re-evaluates every cycle, so it can move from any state to any other; there is no stored state between cycles. The inputs of the operations that lose are dropped for that cycle.

Top module: `cop0_ctrl`

## Requirements
- R1: After reset every register reads as zero and swi_req is low.
- R2: A register write to Status, to EPC or to any number other than 13 stores the data unchanged, and the new value can be read back in the next cycle.
- R3: rd_data is the addressed 32-bit register with its bit 31 copied into every bit above bit 31 (64 bits wide by default).
- R4: A write to Cause stores the data with bits [15:10] cleared. Exceptions never set those bits, so they always read as zero.
- R5: On an exception, Status bits [5:0] become {old[3:0], 2'b00}, and Status bits [31:6] are kept.
- R6: On an exception, Cause bits [6:2] take exc_code and Cause bit 31 takes exc_bd, and the other Cause bits are kept. For example, a system call uses code 8, so the low byte of Cause becomes 0x20.
- R7: On an exception, EPC takes exc_pc when exc_bd is 0, and exc_pc minus 4 when exc_bd is 1.
- R8: On a return from exception with no exception present, Status bits [3:0] take the old bits [5:2], and Status bits [31:4] are kept.
- R9: swi_req is high exactly when (Cause AND Status AND 0x300) is nonzero and Status bit 0 is 1.
- R10: Only one operation takes effect in a cycle. The exception strobe wins over the return strobe and the write, and the return strobe wins over the write. An operation that loses leaves every register unchanged.
- R11: vec_addr always shows 0x80000080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Register number to read |
| rd_data | output | 64 | Sign-extended read data (combinational) |
| exc_en | input | 1 | Exception entry strobe |
| exc_code | input | 5 | Exception code stored in Cause [6:2] |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_bd | input | 1 | Faulting instruction sits in a branch delay slot |
| rfe_en | input | 1 | Return-from-exception strobe |
| swi_req | output | 1 | Software-interrupt exception request |
| vec_addr | output | 32 | Exception handler address |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each rising edge. They also take for granted that register numbers lie below the configured register count, since the decode compares whole addresses. The stimulus changes inputs only at falling edges and draws addresses from the 32 valid numbers. Its pseudo-random phase favours numbers 12 to 14 and mixes strobes that arrive together, so the priority rule and the stack push and pop are exercised from many different Status values.

// File: rtl/cop0_pkg.sv
package cop0_pkg;

    localparam int DW         = 32;
    localparam int REG_STATUS = 12;
    localparam int REG_CAUSE  = 13;
    localparam int REG_EPC    = 14;

    // bits [15:10] of Cause are never stored
    localparam logic [DW-1:0] CAUSE_KEEP = ~32'h0000_FC00;
    // software interrupt pending / mask bits
    localparam logic [DW-1:0] SWI_BITS   = 32'h0000_0300;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_TRAP,
        OP_RFE,
        OP_WRITE
    } cop0_op_e;

endpackage

// File: rtl/cop0_opsel.sv
module cop0_opsel
    import cop0_pkg::*;
(
    input  logic     exc_en,
    input  logic     rfe_en,
    input  logic     wr_en,
    output cop0_op_e op
);

    always_comb begin
        unique casez ({exc_en, rfe_en, wr_en})
            3'b1??:  op = OP_TRAP;
            3'b01?:  op = OP_RFE;
            3'b001:  op = OP_WRITE;
            default: op = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/cop0_status.sv
module cop0_status
    import cop0_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  cop0_op_e      op,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] status_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            unique case (op)
                OP_TRAP:  status_q[5:0] <= {status_q[3:0], 2'b00};
                OP_RFE:   status_q[3:0] <= status_q[5:2];
                OP_WRITE: if (wr_hit) status_q <= wr_data;
                OP_IDLE:  ;
            endcase
        end
    end

    // R5: push keeps upper bits and shifts the three pairs
    a_r5_trap_push: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TRAP) |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00})
                         && (status_q[DW-1:6] == $past(status_q[DW-1:6])));

    // R8: pop restores the previous pair level
    a_r8_rfe_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RFE) |=> (status_q[3:0] == $past(status_q[5:2]))
                        && (status_q[DW-1:4] == $past(status_q[DW-1:4])));

endmodule

// File: rtl/cop0_cause.sv
module cop0_cause
    import cop0_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  cop0_op_e      op,
    input  logic          wr_cause,
    input  logic          wr_epc,
    input  logic [DW-1:0] wr_data,
    input  logic [4:0]    exc_code,
    input  logic [DW-1:0] exc_pc,
    input  logic          exc_bd,
    output logic [DW-1:0] cause_q,
    output logic [DW-1:0] epc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else begin
            unique case (op)
                OP_TRAP: begin
                    cause_q[DW-1] <= exc_bd;
                    cause_q[6:2]  <= exc_code;
                    epc_q         <= exc_bd ? (exc_pc - DW'(4)) : exc_pc;
                end
                OP_WRITE: begin
                    if (wr_cause) cause_q <= wr_data & CAUSE_KEEP;
                    if (wr_epc)   epc_q   <= wr_data;
                end
                OP_RFE:  ;
                OP_IDLE: ;
            endcase
        end
    end

    // R4: the masked field never holds a one
    a_r4_cause_gap: assert property (@(posedge clk) disable iff (!rst_n)
        cause_q[15:10] == 6'b0);

    // R6: code and delay flag captured on entry
    a_r6_cause_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TRAP) |=> (cause_q[DW-1] == $past(exc_bd))
                         && (cause_q[6:2] == $past(exc_code)));

    // R7: restart address adjusted for a delay slot
    a_r7_epc_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TRAP) |=> (epc_q == ($past(exc_bd) ? $past(exc_pc) - DW'(4)
                                                      : $past(exc_pc))));

endmodule

// File: rtl/cop0_bank.sv
module cop0_bank
    import cop0_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] bank_q [NREG]
);

    for (genvar i = 0; i < NREG; i++) begin : g_word
        if (i == REG_STATUS || i == REG_CAUSE || i == REG_EPC) begin : g_special
            assign bank_q[i] = '0;
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bank_q[i] <= '0;
                else if (wr_go && wr_addr == AW'(i))
                    bank_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/cop0_ctrl.sv
module cop0_ctrl
    import cop0_pkg::*;
#(
    parameter int          NREG     = 32,
    parameter int          RD_W     = 64,
    parameter logic [31:0] VEC_ADDR = 32'h8000_0080,
    localparam int         AW       = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [RD_W-1:0] rd_data,
    input  logic            exc_en,
    input  logic [4:0]      exc_code,
    input  logic [DW-1:0]   exc_pc,
    input  logic            exc_bd,
    input  logic            rfe_en,
    output logic            swi_req,
    output logic [DW-1:0]   vec_addr
);

    cop0_op_e      op;
    logic [DW-1:0] status_q;
    logic [DW-1:0] cause_q;
    logic [DW-1:0] epc_q;
    logic [DW-1:0] bank_q [NREG];
    logic [DW-1:0] rd_word;
    logic          wr_go;

    assign wr_go = (op == OP_WRITE);

    cop0_opsel u_opsel (
        .exc_en (exc_en),
        .rfe_en (rfe_en),
        .wr_en  (wr_en),
        .op     (op)
    );

    cop0_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .wr_hit   (wr_addr == AW'(REG_STATUS)),
        .wr_data  (wr_data),
        .status_q (status_q)
    );

    cop0_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .wr_cause (wr_addr == AW'(REG_CAUSE)),
        .wr_epc   (wr_addr == AW'(REG_EPC)),
        .wr_data  (wr_data),
        .exc_code (exc_code),
        .exc_pc   (exc_pc),
        .exc_bd   (exc_bd),
        .cause_q  (cause_q),
        .epc_q    (epc_q)
    );

    cop0_bank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank_q  (bank_q)
    );

    always_comb begin
        rd_word = '0;
        if (rd_addr == AW'(REG_STATUS))
            rd_word = status_q;
        else if (rd_addr == AW'(REG_CAUSE))
            rd_word = cause_q;
        else if (rd_addr == AW'(REG_EPC))
            rd_word = epc_q;
        else if (int'(rd_addr) < NREG)
            rd_word = bank_q[rd_addr];
    end

    if (RD_W > DW) begin : g_sext
        assign rd_data = {{(RD_W-DW){rd_word[DW-1]}}, rd_word};
    end else begin : g_trunc
        assign rd_data = rd_word[RD_W-1:0];
    end

    assign swi_req  = (|(cause_q & status_q & SWI_BITS)) && status_q[0];
    assign vec_addr = VEC_ADDR;

    // R9: a request never appears with the global enable clear
    a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        swi_req |-> status_q[0]);

    // R9: a request needs an unmasked pending bit
    a_r9_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        swi_req |-> ((cause_q[9:8] & status_q[9:8]) != 2'b00));

    // R10: an exception beats a simultaneous return or write
    a_r10_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_en && (rfe_en || wr_en)) |=>
            (status_q[5:0] == {$past(status_q[3:0]), 2'b00}));

    // R10: a return beats a simultaneous write to Status
    a_r10_rfe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_en && rfe_en && wr_en) |=>
            (status_q[DW-1:4] == $past(status_q[DW-1:4])));

endmodule

// File: tb/tb_cop0_ctrl.sv
`timescale 1ns/1ps
module tb_cop0_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        exc_en = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic        exc_bd = 1'b0;
    logic        rfe_en = 1'b0;
    logic        swi_req;
    logic [31:0] vec_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] m [32];
    logic [31:0] lf = 32'hACE1_1234;

    always #4 clk = ~clk;

    cop0_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .exc_en   (exc_en),
        .exc_code (exc_code),
        .exc_pc   (exc_pc),
        .exc_bd   (exc_bd),
        .rfe_en   (rfe_en),
        .swi_req  (swi_req),
        .vec_addr (vec_addr)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference update from the requirement text
    task automatic model_update();
        logic [31:0] s;
        logic [31:0] c;
        if (exc_en) begin
            s = m[12];
            m[12] = {s[31:6], s[3:0], 2'b00};
            c = m[13];
            c[6:2] = exc_code;
            c[31] = exc_bd;
            m[13] = c;
            m[14] = exc_bd ? exc_pc - 32'd4 : exc_pc;
        end else if (rfe_en) begin
            m[12][3:0] = m[12][5:2];
        end else if (wr_en) begin
            m[wr_addr] = (wr_addr == 5'd13) ? (wr_data & 32'hFFFF_03FF) : wr_data;
        end
    endtask

    task automatic compare(input string tag);
        logic [63:0] exp;
        logic        sw;
        exp = {{32{m[rd_addr][31]}}, m[rd_addr]};
        check(rd_data === exp, tag, rd_data, exp);
        sw = ((m[13] & m[12] & 32'h300) != 0) && m[12][0];
        check(swi_req === sw, "R9", {63'd0, swi_req}, {63'd0, sw});
        check(vec_addr === 32'h8000_0080, "R11", {32'd0, vec_addr}, 64'h8000_0080);
    endtask

    task automatic step(input bit e, input bit rf, input bit w,
                        input logic [4:0] wa, input logic [31:0] wd,
                        input logic [4:0] code, input logic [31:0] pc,
                        input bit bd, input logic [4:0] ra, input string tag);
        exc_en = e; rfe_en = rf; wr_en = w;
        wr_addr = wa; wr_data = wd;
        exc_code = code; exc_pc = pc; exc_bd = bd;
        rd_addr = ra;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        step(0, 0, 1, a, d, 0, 0, 0, a, tag);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, a, tag);
    endtask

    task automatic lf_next();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(5'd12, "R1");
        rd(5'd13, "R1");
        rd(5'd14, "R1");
        rd(5'd3,  "R1");

        // R2: plain stores
        wr(5'd12, 32'h0000_0015, "R2");
        wr(5'd14, 32'h1234_5678, "R2");
        wr(5'd0,  32'h0BAD_F00D, "R2");
        wr(5'd31, 32'h7FFF_FFFF, "R2");
        // R3: negative values sign-extend
        wr(5'd7,  32'h8000_0001, "R3");
        wr(5'd14, 32'hFFFF_FFF0, "R3");

        // R4: Cause write mask
        wr(5'd13, 32'hFFFF_FFFF, "R4");
        wr(5'd13, 32'h0000_FC00, "R4");

        // R5, R6, R7: system call entry, not in delay slot
        step(1, 0, 0, 0, 0, 5'd8, 32'h0000_1000, 0, 5'd12, "R5");
        rd(5'd13, "R6");
        rd(5'd14, "R7");
        // second nested entry in delay slot
        step(1, 0, 0, 0, 0, 5'd4, 32'h0000_2000, 1, 5'd14, "R7");
        rd(5'd13, "R6");
        rd(5'd12, "R5");

        // R8: two returns
        wr(5'd12, 32'hA5A5_A53C, "R8");
        step(0, 1, 0, 0, 0, 0, 0, 0, 5'd12, "R8");
        step(0, 1, 0, 0, 0, 0, 0, 0, 5'd12, "R8");

        // R9: software interrupt gating
        wr(5'd13, 32'h0000_0100, "R9");
        wr(5'd12, 32'h0000_0301, "R9");
        wr(5'd12, 32'h0000_0300, "R9");
        wr(5'd12, 32'h0000_0201, "R9");
        wr(5'd13, 32'h0000_0200, "R9");
        wr(5'd13, 32'h0000_0000, "R9");

        // R10: priority between simultaneous strobes
        wr(5'd12, 32'h0000_003F, "R10");
        wr(5'd5,  32'h1111_1111, "R10");
        step(1, 1, 1, 5'd5, 32'h2222_2222, 5'd9, 32'h0000_4000, 0, 5'd5, "R10");
        rd(5'd12, "R10");
        step(0, 1, 1, 5'd5, 32'h3333_3333, 0, 0, 0, 5'd5, "R10");
        rd(5'd12, "R10");
        step(1, 0, 1, 5'd14, 32'hDEAD_BEEF, 5'd1, 32'h0000_5000, 0, 5'd14, "R10");

        // mixed pseudo-random traffic
        for (int k = 0; k < 400; k++) begin
            logic [4:0] a;
            logic [4:0] r;
            lf_next();
            a = lf[4] ? (5'd12 + {3'd0, lf[6:5]} % 5'd3) : lf[12:8];
            r = lf[13] ? (5'd12 + {3'd0, lf[15:14]} % 5'd3) : lf[20:16];
            step(lf[0] & lf[1] & lf[2], lf[3] & lf[7], lf[21] | lf[22],
                 a, {lf[31:16], lf[15:0] ^ 16'h5A5A}, lf[27:23],
                 {lf[30:2], 2'b00}, lf[31], r, "R10");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule